// File: doc/BRIEF.md
# CPU Clock Source Selector with Ping-Pong Banks

This block picks the clock that a CPU domain runs on. Each possible source is modelled as a one-cycle enable strobe inside a single fast clock domain, and the block produces one output enable strobe, `cpu_tick`. A final multiplexer chooses between the system PLL strobe and a dynamic path. The dynamic path is driven by one of two configuration banks. Each bank holds a source code, a divider-bypass bit and a 6-bit divider value. Software changes the dynamic clock by writing the new setting into the idle bank and inverting the bank-select bit in the same write. The bank that is in use is never rewritten in place.

After a bank-select change, a switch state machine moves through three states. ST_IDLE goes to ST_DRAIN on a write that inverts the select bit. In ST_DRAIN the dynamic output is held off. The machine stays there until the old bank's source has strobed twice. It then goes to ST_ARM, and the new bank drives the output from that cycle on. ST_ARM returns to ST_IDLE after one cycle. The busy flag is high in ST_DRAIN and ST_ARM.

A second register holds three 3-bit ratio fields. Each field turns `cpu_tick` into a slower enable strobe for one derived bus clock.

Top module: `cpu_clk_select`

## Requirements
- R1: After reset, the control register reads 0x0400_0000 and the ratio register reads 0. The dynamic path is selected, bank 0 is active with source code 0 and the divider bypassed, the enable is on, and `busy` is low.
- R2: Control bit 11 high makes `cpu_tick` equal to `pll_tick`. Bit 11 low routes the active dynamic bank to `cpu_tick`.
- R3: Control bit 26 low forces `cpu_tick` low.
- R4: Source code 1 selects `fix_half_tick` and code 2 selects `fix_third_tick`. Codes 0 and 3 select `xtal_tick`.
- R5: When the bank's bypass bit is 0, every strobe of the selected source produces a `cpu_tick`. When it is 1, every (d+1)-th source strobe produces one, where d is the divider field. Counting restarts from zero each time the bank becomes active.
- R6: Bank 0 fields sit at control bits [1:0] (source), [2] (bypass bit) and [9:4] (divider). Bank 1 fields sit at bits [17:16], [18] and [25:20]. Bit 10 reads back the requested bank.
- R7: A control write that leaves bit 10 unchanged updates only the idle bank's fields. The active bank's fields and its output are unaffected.
- R8: A write that inverts bit 10 while `busy` is low raises `busy` (also visible as control bit 28) on the next cycle. The dynamic output is held off until two strobes of the old bank's source have been seen. The new bank drives `cpu_tick` from the next cycle, and `busy` falls one cycle later.
- R9: While `busy` is high, control writes leave bit 10 and both banks' fields unchanged. Bits 26 and 11 are still taken.
- R10: Ratio register fields [5:3], [8:6] and [11:9] give bus ratios equal to field+2. `bus_tick[i]` pulses together with every (field+2)-th `cpu_tick`. A ratio write restarts all three counts.
- R11: Control bit 28 cannot be written. It always reads as the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick | input | 1 | Crystal source strobe |
| fix_half_tick | input | 1 | Fixed PLL divide-by-2 source strobe |
| fix_third_tick | input | 1 | Fixed PLL divide-by-3 source strobe |
| pll_tick | input | 1 | System PLL strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 the ratio register |
| wr_data | input | 32 | Write data |
| ctrl_rd | output | 32 | Control register readback |
| ratio_rd | output | 32 | Ratio register readback |
| busy | output | 1 | Bank switch in progress |
| cpu_tick | output | 1 | CPU clock enable strobe |
| bus_tick | output | 3 | Derived bus clock enable strobes |

## Verification
The assertions assume two things. First, the active bank's configuration is never rewritten, which the block enforces by accepting writes only into the idle bank. Second, the old bank's source keeps strobing, so that ST_DRAIN is left. The bench therefore drives every source with a free-running periodic pattern and gives each source a different period, so that a wrong source selection shows up at the output. A behavioural model in the bench predicts every output on every cycle. The stimulus includes writes placed deliberately inside the busy window and ratio rewrites made in the middle of a count.

// File: rtl/cpusel_pkg.sv
package cpusel_pkg;

    localparam int PRE_W       = 2;
    localparam int DIV_W       = 6;
    localparam int RAT_W       = 3;
    localparam int N_BUS       = 3;
    localparam int N_SRC       = 1 << PRE_W;
    localparam int DRAIN_TICKS = 2;

    localparam int BIT_SEL  = 10;
    localparam int BIT_FSEL = 11;
    localparam int BIT_EN   = 26;
    localparam int BIT_BUSY = 28;
    localparam int BANK1_BASE = 16;
    localparam int RAT_BASE   = 3;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             post;
        logic [DIV_W-1:0] div;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_ARM   = 2'd2
    } sw_state_e;

    function automatic int bank_base(input logic idx);
        return idx ? BANK1_BASE : 0;
    endfunction

    function automatic bank_cfg_t unpack_bank(input logic [31:0] w, input logic idx);
        bank_cfg_t r;
        int b;
        b = bank_base(idx);
        r.pre  = w[b +: PRE_W];
        r.post = w[b + 2];
        r.div  = w[b + 4 +: DIV_W];
        return r;
    endfunction

    function automatic logic [31:0] pack_bank(input bank_cfg_t c, input logic idx);
        logic [31:0] w;
        int b;
        b = bank_base(idx);
        w = '0;
        w[b +: PRE_W]     = c.pre;
        w[b + 2]          = c.post;
        w[b + 4 +: DIV_W] = c.div;
        return w;
    endfunction

endpackage

// File: rtl/cpusel_bank_div.sv
module cpusel_bank_div
    import cpusel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  bank_cfg_t        cfg,
    input  logic [N_SRC-1:0] src_vec,
    output logic             src_hit,
    output logic             ce
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign src_hit = src_vec[cfg.pre];
    assign at_end  = (cnt_q == cfg.div);
    assign ce      = src_hit && (!cfg.post || at_end);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (src_hit) begin
            if (!cfg.post || at_end)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: divider count never passes the divider field of the running bank
    p_div_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cfg.post) |-> (cnt_q <= cfg.div));

endmodule

// File: rtl/cpusel_switch_fsm.sv
module cpusel_switch_fsm
    import cpusel_pkg::*;
#(
    parameter int DRAIN_N = DRAIN_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic old_hit,
    output logic busy,
    output logic gate_on,
    output logic active_bank
);

    localparam int CNT_W = $clog2(DRAIN_N) + 1;

    sw_state_e       state_q, state_d;
    logic [CNT_W-1:0] dcnt_q, dcnt_d;
    logic             active_q, active_d;

    always_comb begin
        state_d  = state_q;
        dcnt_d   = dcnt_q;
        active_d = active_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_DRAIN;
                    dcnt_d  = '0;
                end
            end
            ST_DRAIN: begin
                if (old_hit) begin
                    if (dcnt_q == CNT_W'(DRAIN_N - 1)) begin
                        state_d  = ST_ARM;
                        active_d = !active_q;
                        dcnt_d   = '0;
                    end else begin
                        dcnt_d = dcnt_q + 1'b1;
                    end
                end
            end
            ST_ARM: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dcnt_q   <= '0;
            active_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            dcnt_q   <= dcnt_d;
            active_q <= active_d;
        end
    end

    always_comb begin
        busy        = (state_q != ST_IDLE);
        gate_on     = (state_q != ST_DRAIN);
        active_bank = active_q;
    end

    // R8: a switch request raises busy on the following cycle
    p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |=> (state_q == ST_DRAIN));

    // R8: the arm state lasts exactly one cycle
    p_arm_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> (state_q == ST_IDLE));

    // R8: the running bank only changes when draining ends
    p_active_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> (state_q == ST_ARM));

endmodule

// File: rtl/cpusel_ratio_div.sv
module cpusel_ratio_div
    import cpusel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ce_in,
    input  logic [RAT_W-1:0] field,
    output logic             tick
);

    localparam int CNT_W = RAT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    assign lim  = {1'b0, field} + 1'b1;
    assign tick = ce_in && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (ce_in) begin
            if (cnt_q == lim)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: the ratio count stays within the programmed ratio
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

endmodule

// File: rtl/cpu_clk_select.sv
module cpu_clk_select
    import cpusel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xtal_tick,
    input  logic        fix_half_tick,
    input  logic        fix_third_tick,
    input  logic        pll_tick,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_rd,
    output logic [31:0] ratio_rd,
    output logic        busy,
    output logic        cpu_tick,
    output logic [2:0]  bus_tick
);

    logic             en_q, fsel_q, sel_q;
    bank_cfg_t        bank_q [2];
    logic [RAT_W-1:0] rat_q [N_BUS];

    logic             wr_ctrl, wr_ratio, start;
    logic [N_SRC-1:0] src_vec;
    logic [1:0]       bank_hit, bank_ce;
    logic             gate_on, active_bank;

    assign wr_ctrl  = wr_en && !wr_addr;
    assign wr_ratio = wr_en &&  wr_addr;
    assign start    = wr_ctrl && !busy && (wr_data[BIT_SEL] != sel_q);
    assign src_vec  = {xtal_tick, fix_third_tick, fix_half_tick, xtal_tick};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b1;
            fsel_q    <= 1'b0;
            sel_q     <= 1'b0;
            bank_q[0] <= '0;
            bank_q[1] <= '0;
        end else if (wr_ctrl) begin
            en_q   <= wr_data[BIT_EN];
            fsel_q <= wr_data[BIT_FSEL];
            if (!busy) begin
                bank_q[!sel_q] <= unpack_bank(wr_data, !sel_q);
                sel_q          <= wr_data[BIT_SEL];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BUS; i++) rat_q[i] <= '0;
        end else if (wr_ratio) begin
            for (int i = 0; i < N_BUS; i++)
                rat_q[i] <= wr_data[RAT_BASE + RAT_W*i +: RAT_W];
        end
    end

    genvar gb;
    generate
        for (gb = 0; gb < 2; gb++) begin : g_bank
            cpusel_bank_div u_div (
                .clk     (clk),
                .rst_n   (rst_n),
                .active  (active_bank == 1'(gb)),
                .cfg     (bank_q[gb]),
                .src_vec (src_vec),
                .src_hit (bank_hit[gb]),
                .ce      (bank_ce[gb])
            );
        end
    endgenerate

    cpusel_switch_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .old_hit     (bank_hit[active_bank]),
        .busy        (busy),
        .gate_on     (gate_on),
        .active_bank (active_bank)
    );

    always_comb begin
        if (!en_q)
            cpu_tick = 1'b0;
        else if (fsel_q)
            cpu_tick = pll_tick;
        else
            cpu_tick = gate_on && bank_ce[active_bank];
    end

    genvar gr;
    generate
        for (gr = 0; gr < N_BUS; gr++) begin : g_bus
            cpusel_ratio_div u_rat (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (wr_ratio),
                .ce_in (cpu_tick),
                .field (rat_q[gr]),
                .tick  (bus_tick[gr])
            );
        end
    endgenerate

    always_comb begin
        ctrl_rd = pack_bank(bank_q[0], 1'b0) | pack_bank(bank_q[1], 1'b1);
        ctrl_rd[BIT_SEL]  = sel_q;
        ctrl_rd[BIT_FSEL] = fsel_q;
        ctrl_rd[BIT_EN]   = en_q;
        ctrl_rd[BIT_BUSY] = busy;
        ratio_rd = '0;
        for (int i = 0; i < N_BUS; i++)
            ratio_rd[RAT_BASE + RAT_W*i +: RAT_W] = rat_q[i];
    end

    // R9: bank contents and the requested bank hold while a switch runs
    p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(bank_q[0]) && $stable(bank_q[1]) && $stable(sel_q)));

    // R7: outside a switch the running bank is the requested bank
    p_active_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (active_bank == sel_q));

endmodule

// File: tb/cpu_clk_select_bench.sv
module cpu_clk_select_bench;

    localparam int CLK_PERIOD = 10;
    localparam int EN = 1 << 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b0, fix_half_tick = 1'b0, fix_third_tick = 1'b0, pll_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_rd, ratio_rd;
    logic        busy, cpu_tick;
    logic [2:0]  bus_tick;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // reference model state
    int m_en, m_fsel, m_sel, m_act, m_st, m_dc;
    int m_pre[2], m_post[2], m_div[2], m_cnt[2];
    int m_rf[3], m_rc[3];

    cpu_clk_select u_cpu_clk_select (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .fix_half_tick(fix_half_tick),
        .fix_third_tick(fix_third_tick), .pll_tick(pll_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_rd(ctrl_rd), .ratio_rd(ratio_rd),
        .busy(busy), .cpu_tick(cpu_tick), .bus_tick(bus_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int src_of(int pre);
        if (pre == 1) return int'(fix_half_tick);
        if (pre == 2) return int'(fix_third_tick);
        return int'(xtal_tick);
    endfunction

    function automatic int bank_ce(int b);
        return (src_of(m_pre[b]) != 0 && (m_post[b] == 0 || m_cnt[b] == m_div[b])) ? 1 : 0;
    endfunction

    function automatic int exp_cpu();
        if (m_en == 0) return 0;
        if (m_fsel != 0) return int'(pll_tick);
        if (m_st == 1) return 0;
        return bank_ce(m_act);
    endfunction

    function automatic logic [2:0] exp_bus();
        logic [2:0] v;
        for (int i = 0; i < 3; i++)
            v[i] = (exp_cpu() != 0 && m_rc[i] == m_rf[i] + 1);
        return v;
    endfunction

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] w;
        w = '0;
        w[1:0]   = 2'(m_pre[0]);
        w[2]     = m_post[0][0];
        w[9:4]   = 6'(m_div[0]);
        w[17:16] = 2'(m_pre[1]);
        w[18]    = m_post[1][0];
        w[25:20] = 6'(m_div[1]);
        w[10]    = m_sel[0];
        w[11]    = m_fsel[0];
        w[26]    = m_en[0];
        w[28]    = (m_st != 0);
        return w;
    endfunction

    function automatic logic [31:0] exp_ratio();
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < 3; i++) w[3 + 3*i +: 3] = 3'(m_rf[i]);
        return w;
    endfunction

    task automatic model_reset();
        m_en = 1; m_fsel = 0; m_sel = 0; m_act = 0; m_st = 0; m_dc = 0;
        for (int b = 0; b < 2; b++) begin
            m_pre[b] = 0; m_post[b] = 0; m_div[b] = 0; m_cnt[b] = 0;
        end
        for (int i = 0; i < 3; i++) begin
            m_rf[i] = 0; m_rc[i] = 0;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int ce, hit, n_st, n_dc, n_act, idle, start;
            ce = exp_cpu();
            // bank counters
            for (int b = 0; b < 2; b++) begin
                if (b != m_act) m_cnt[b] = 0;
                else if (src_of(m_pre[b]) != 0) begin
                    if (m_post[b] == 0 || m_cnt[b] == m_div[b]) m_cnt[b] = 0;
                    else m_cnt[b] = m_cnt[b] + 1;
                end
            end
            // bus counters
            if (wr_en && wr_addr) begin
                for (int i = 0; i < 3; i++) m_rc[i] = 0;
            end else if (ce != 0) begin
                for (int i = 0; i < 3; i++)
                    m_rc[i] = (m_rc[i] == m_rf[i] + 1) ? 0 : m_rc[i] + 1;
            end
            // switch sequencing
            start = (wr_en && !wr_addr && m_st == 0 && int'(wr_data[10]) != m_sel) ? 1 : 0;
            n_st = m_st; n_dc = m_dc; n_act = m_act;
            hit = src_of(m_pre[m_act]);
            if (m_st == 0 && start != 0) begin
                n_st = 1; n_dc = 0;
            end else if (m_st == 1 && hit != 0) begin
                if (m_dc == 1) begin
                    n_st = 2; n_dc = 0; n_act = 1 - m_act;
                end else n_dc = m_dc + 1;
            end else if (m_st == 2) n_st = 0;
            // register writes
            if (wr_en && !wr_addr) begin
                m_en = int'(wr_data[26]);
                m_fsel = int'(wr_data[11]);
                if (m_st == 0) begin
                    idle = 1 - m_sel;
                    if (idle == 0) begin
                        m_pre[0] = int'(wr_data[1:0]); m_post[0] = int'(wr_data[2]);
                        m_div[0] = int'(wr_data[9:4]);
                    end else begin
                        m_pre[1] = int'(wr_data[17:16]); m_post[1] = int'(wr_data[18]);
                        m_div[1] = int'(wr_data[25:20]);
                    end
                    m_sel = int'(wr_data[10]);
                end
            end
            if (wr_en && wr_addr) begin
                for (int i = 0; i < 3; i++) m_rf[i] = int'(wr_data[3 + 3*i +: 3]);
            end
            m_st = n_st; m_dc = n_dc; m_act = n_act;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " cpu_tick"}, 32'(cpu_tick), 32'(exp_cpu()));
            chk({cur_req, " bus_tick"}, 32'(bus_tick), 32'(exp_bus()));
            chk({cur_req, " busy"},     32'(busy),     32'(m_st != 0));
            chk({cur_req, " ctrl_rd"},  ctrl_rd,       exp_ctrl());
            chk({cur_req, " ratio_rd"}, ratio_rd,      exp_ratio());
        end
    end

    // free-running source strobes with distinct periods
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            xtal_tick      = (cyc % 3 == 0);
            fix_half_tick  = (cyc % 2 == 1);
            fix_third_tick = (cyc % 5 == 2);
            pll_tick       = (cyc % 4 != 3);
        end
    end

    task automatic wr(input logic a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle_cycles(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_not_busy(string req);
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        chk({req, " switch completes"}, 32'(busy), 32'd0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 ctrl reset", ctrl_rd, 32'h0400_0000);
        chk("R1 ratio reset", ratio_rd, 32'h0);
        chk("R1 busy reset", 32'(busy), 32'h0);
        idle_cycles(20);

        cur_req = "R2";
        wr(1'b0, EN | (1 << 11));
        idle_cycles(20);
        wr(1'b0, EN);
        idle_cycles(10);

        cur_req = "R3";
        wr(1'b0, 0);
        idle_cycles(12);
        @(negedge clk);
        chk("R3 enable off", 32'(cpu_tick), 32'h0);
        wr(1'b0, EN);

        cur_req = "R7";
        wr(1'b0, EN | (1 << 16) | (1 << 18) | (2 << 20) | 2);
        @(negedge clk);
        chk("R7 active bank untouched", {22'h0, ctrl_rd[9:0]}, 32'h0);
        chk("R6 idle bank fields", {22'h0, ctrl_rd[25:16]}, 32'h25);
        idle_cycles(12);

        cur_req = "R8";
        wr(1'b0, EN | (1 << 10) | (1 << 16) | (1 << 18) | (2 << 20));
        @(negedge clk);
        chk("R8 busy raised", 32'(busy), 32'h1);
        chk("R8 busy readback", 32'(ctrl_rd[28]), 32'h1);
        cur_req = "R9";
        wr(1'b0, EN | 1 | (1 << 4));
        wait_not_busy("R9");
        chk("R9 select kept", 32'(ctrl_rd[10]), 32'h1);
        chk("R9 bank0 kept", {22'h0, ctrl_rd[9:0]}, 32'h0);
        cur_req = "R5";
        idle_cycles(40);

        cur_req = "R4";
        wr(1'b0, EN | 2);
        wait_not_busy("R4");
        idle_cycles(30);
        wr(1'b0, EN | (1 << 10) | (3 << 16) | (1 << 18) | (5 << 20));
        wait_not_busy("R5");
        cur_req = "R5";
        idle_cycles(50);

        cur_req = "R10";
        wr(1'b0, EN | (1 << 10) | (1 << 11));
        wr(1'b1, (0 << 3) | (3 << 6) | (6 << 9));
        @(negedge clk);
        chk("R10 ratio readback", ratio_rd, 32'h0000_0cc0);
        idle_cycles(37);
        wr(1'b1, (1 << 3) | (0 << 6) | (7 << 9));
        idle_cycles(60);

        cur_req = "R11";
        wr(1'b0, EN | (1 << 28) | (1 << 10));
        @(negedge clk);
        chk("R11 busy not writable", 32'(ctrl_rd[28]), 32'h0);

        cur_req = "R9";
        wr(1'b0, EN | (1 << 1));
        wr(1'b0, (1 << 11));
        @(negedge clk);
        chk("R9 enable taken while busy", 32'(ctrl_rd[26]), 32'h0);
        wait_not_busy("R9");
        wr(1'b0, EN);
        idle_cycles(20);

        summary();
        $finish;
    end

endmodule